// File: doc/BRIEF.md
# Bit-Reversed Real-Sample Acquisition Writer

This block takes a stream of real time-domain samples, one per valid/ready handshake. It places each sample straight into the slot of a complex working buffer that a radix-2 decimation-in-time FFT expects. Sample number `i` of a frame goes into complex slot `bitrev(i)`, where the reversal spans log2(N) bits. The sample is written as the real word of that slot, and the imaginary word of the slot is cleared. Because of this, the buffer needs no separate reordering pass before an in-place transform.

The buffer holds 2N words. Each complex slot is two adjacent words, with the real word at the even address and the imaginary word at the odd address. The buffer sits on a 2N-word boundary, and the caller names it by a region number. A memory word address is therefore formed by plain concatenation:

- the region number,
- then the reversed index,
- then one bit that selects the real or the imaginary word.

The memory port takes one write per cycle, so each sample costs two cycles. After N samples the block raises a full flag and refuses input until a restart pulse begins a new frame.

Top module: `bitrev_acq_writer`

## Requirements
- R1: After reset, `s_ready` is 1, `full` is 0 and `mem_we` is 0.
- R2: In the cycle where `s_valid` and `s_ready` are both 1, `mem_we` is 1 and `mem_wdata` equals `s_data`. In that same cycle `mem_addr` bit 0 is 0, which selects the real word.
- R3: In the cycle after an accepted sample, `mem_we` is 1, `mem_addr` bit 0 is 1, the other address bits match the preceding real write, `mem_wdata` is 0 and `s_ready` is 0.
- R4: The k-th accepted sample of a frame (k counted from 0) is written to complex slot `bitrev(k)` on log2(N) bits. That slot appears on `mem_addr[log2(N):1]`.
- R5: `mem_addr` bits above bit log2(N) equal the `base_slot` value seen in the cycle where the sample is accepted.
- R6: `full` rises in the cycle after the imaginary write of the N-th sample. From then on `s_ready` stays 0 and `mem_we` stays 0, even while `s_valid` is held at 1.
- R7: A cycle with `restart` at 1 performs no write and accepts no sample. It clears `full` and the sample count, even when it arrives in the middle of a sample pair. The next accepted sample goes to slot 0.
- R8: With `s_valid` at 0 and no imaginary write pending, `mem_we` is 0.
- R9: With `s_valid` held at 1, samples are accepted on every other cycle, giving one sample per two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Start a new frame; clears the count and the full flag |
| base_slot | input | ADDR_W-LOG2N-1 | Region number of the 2N-word aligned buffer |
| s_valid | input | 1 | Input sample present |
| s_data | input | DATA_W | Real input sample |
| s_ready | output | 1 | Block can take a sample this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| full | output | 1 | N samples of the frame are stored |

## Verification
A wrong sample counter shows at once on the slot bits of the very next real write. The bench checks every write address of a full frame, so a slip is caught on the first sample it affects. A phase register stuck in one state shows within one cycle: either the imaginary write is missing after an accept, or `s_ready` rises during it. A late or early full flag is caught in the cycle after the last imaginary write, because that cycle either still accepts a sample or already refuses one.

// File: rtl/bitrev_acq_pkg.sv
// Package: shared types for the bit-reversed acquisition writer.
// Assumes: nothing beyond standard SystemVerilog.
package bitrev_acq_pkg;

    // Which word of a complex slot is being written.
    typedef enum logic {
        PH_REAL = 1'b0,
        PH_IMAG = 1'b1
    } acq_phase_e;

endpackage

// File: rtl/bitrev_acq_reverse.sv
// Module: reverses the bit order of a sample index.
// Assumes: IDX_W >= 1; purely combinational wiring, no logic levels.
module bitrev_acq_reverse #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx_in,
    output logic [IDX_W-1:0] idx_rev
);

    // Cross-wire bit b to bit IDX_W-1-b.
    for (genvar b = 0; b < IDX_W; b++) begin : g_rev
        assign idx_rev[b] = idx_in[IDX_W-1-b];
    end

    // R4: reversing twice returns the original index.
    always_comb begin
        for (int b = 0; b < IDX_W; b++) begin
            p_involution_r4: assert (idx_rev[IDX_W-1-b] === idx_in[b] || $isunknown(idx_in));
        end
    end

endmodule

// File: rtl/bitrev_acq_seq.sv
// Module: sequences one real write and one imaginary write per sample,
// counts the samples of a frame, and holds the full flag.
// Assumes: NPTS is a power of two; restart has priority over everything.
module bitrev_acq_seq
    import bitrev_acq_pkg::*;
#(
    parameter int NPTS  = 16,
    parameter int LOG2N = $clog2(NPTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             s_valid,
    output logic             s_ready,
    output logic             accept,
    output logic             wr_en,
    output logic             wr_imag,
    output logic [LOG2N-1:0] idx,
    output logic             full
);

    localparam int CNT_W = LOG2N + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NPTS - 1);
    localparam logic [CNT_W-1:0] TOTAL = CNT_W'(NPTS);

    acq_phase_e       phase_q;
    logic [CNT_W-1:0] count_q;
    logic             full_q;

    // Ready only between pairs, before full, and outside a restart cycle.
    assign s_ready = !full_q && (phase_q == PH_REAL) && !restart;
    assign accept  = s_valid && s_ready;
    assign wr_en   = accept || ((phase_q == PH_IMAG) && !restart);
    assign wr_imag = (phase_q == PH_IMAG);
    assign idx     = count_q[LOG2N-1:0];
    assign full    = full_q;

    // Advance phase, count finished pairs, set full after the last pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_REAL;
            count_q <= '0;
            full_q  <= 1'b0;
        end else if (restart) begin
            phase_q <= PH_REAL;
            count_q <= '0;
            full_q  <= 1'b0;
        end else if (phase_q == PH_REAL) begin
            if (accept) begin
                phase_q <= PH_IMAG;
            end
        end else begin
            phase_q <= PH_REAL;
            count_q <= count_q + 1'b1;
            if (count_q == LAST) begin
                full_q <= 1'b1;
            end
        end
    end

    // R6: the count never passes the frame length.
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= TOTAL);
    // R6: a full buffer refuses input.
    p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> !s_ready);
    // R3: no sample is taken during the imaginary write.
    p_imag_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IMAG) |-> !s_ready);
    // R3: an accept is followed by an imaginary write unless restarted.
    p_pair_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (restart || (wr_en && wr_imag)));
    // R7: restart leaves a cleared, non-full frame.
    p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!full_q && count_q == '0));

endmodule

// File: rtl/bitrev_acq_addr.sv
// Module: forms the memory word address of a write from the region
// number, the reversed sample index and the word select bit.
// Assumes: the buffer is aligned on 2*NPTS words, so concatenation suffices.
// The region number is held from the real write into the imaginary write.
module bitrev_acq_addr #(
    parameter int LOG2N  = 4,
    parameter int ADDR_W = 10,
    parameter int REG_W  = ADDR_W - LOG2N - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              wr_imag,
    input  logic [REG_W-1:0]  base_slot,
    input  logic [LOG2N-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    logic [LOG2N-1:0] slot;
    logic [REG_W-1:0] region_q;
    logic [REG_W-1:0] region;

    bitrev_acq_reverse #(.IDX_W(LOG2N)) u_rev (
        .idx_in  (idx),
        .idx_rev (slot)
    );

    // Keep the region of the accepted sample for its imaginary write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= '0;
        end else if (accept) begin
            region_q <= base_slot;
        end
    end

    // Take the live region on the real write, the held one afterwards.
    assign region = accept ? base_slot : region_q;
    assign addr   = {region, slot, wr_imag};

    // R5: the imaginary write stays in the region of its real write.
    p_region_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (region_q == $past(base_slot)));

endmodule

// File: rtl/bitrev_acq_writer.sv
// Module: top of the bit-reversed real-sample acquisition writer.
// Each handshaked sample becomes a real write at the reversed slot,
// followed next cycle by a zero write to the imaginary word.
// Assumes: NPTS a power of two >= 2; ADDR_W > log2(NPTS) + 1.
module bitrev_acq_writer #(
    parameter int NPTS   = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10,
    parameter int LOG2N  = $clog2(NPTS),
    parameter int REG_W  = ADDR_W - LOG2N - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [REG_W-1:0]  base_slot,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              full
);

    logic             accept;
    logic             wr_imag;
    logic [LOG2N-1:0] idx;

    bitrev_acq_seq #(.NPTS(NPTS), .LOG2N(LOG2N)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .accept  (accept),
        .wr_en   (mem_we),
        .wr_imag (wr_imag),
        .idx     (idx),
        .full    (full)
    );

    bitrev_acq_addr #(.LOG2N(LOG2N), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .wr_imag   (wr_imag),
        .base_slot (base_slot),
        .idx       (idx),
        .addr      (mem_addr)
    );

    // Imaginary words are always cleared; real words carry the sample.
    assign mem_wdata = wr_imag ? '0 : s_data;

    // R3: an odd-address write carries zero data.
    p_imag_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr[0]) |-> (mem_wdata == '0));
    // R2: an accepted sample is written to an even address.
    p_real_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |-> (mem_we && !mem_addr[0] && mem_wdata == s_data));
    // R7: a restart cycle writes nothing.
    p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !mem_we);

endmodule

// File: tb/sim_bitrev_acq_writer.sv
module sim_bitrev_acq_writer;
    localparam int NPTS = 16, DATA_W = 16, ADDR_W = 10, LOG2N = 4;
    localparam int REG_W = ADDR_W - LOG2N - 1;

    // Stimulus table: sample value per arrival index, and an idle gap after it.
    typedef struct packed { logic [15:0] smp; logic gap; } vec_t;
    localparam vec_t TBL [16] = '{
        '{16'h1001, 1'b0}, '{16'h2002, 1'b1}, '{16'h3003, 1'b0}, '{16'hF004, 1'b0},
        '{16'h0005, 1'b1}, '{16'h8006, 1'b0}, '{16'h7FFF, 1'b0}, '{16'hFFFF, 1'b1},
        '{16'h1239, 1'b0}, '{16'hABCD, 1'b0}, '{16'h0000, 1'b1}, '{16'h5A5A, 1'b0},
        '{16'hA5A5, 1'b0}, '{16'h00FF, 1'b1}, '{16'hFF00, 1'b0}, '{16'h4321, 1'b0}};

    logic clk = 0, rst_n = 0, restart = 0, s_valid = 0;
    logic [REG_W-1:0] base_slot = '0;
    logic [DATA_W-1:0] s_data = '0;
    logic s_ready, mem_we, full;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bitrev_acq_writer #(.NPTS(NPTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart), .base_slot(base_slot),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .full(full));

    function automatic int rev(int k);
        int r = 0;
        for (int b = 0; b < LOG2N; b++) if (k[b]) r |= 1 << (LOG2N - 1 - b);
        return r;
    endfunction

    function automatic int exp_addr(int region, int k, int imag);
        return (region << (LOG2N + 1)) | (rev(k) << 1) | imag;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Offer one sample at the next negedge, check the real and imaginary writes.
    task automatic put(int k, logic [15:0] d, int region, bit hold);
        @(negedge clk);
        s_valid = 1; s_data = d; base_slot = REG_W'(region);
        #1;
        chk("R2 ready", int'(s_ready), 1);
        chk("R2 we", int'(mem_we), 1);
        chk("R2 data", int'(mem_wdata), int'(d));
        chk("R4/R5 real addr", int'(mem_addr), exp_addr(region, k, 0));
        @(negedge clk);
        if (!hold) s_valid = 0;
        base_slot = ~base_slot;
        #1;
        chk("R3 we", int'(mem_we), 1);
        chk("R3 ready", int'(s_ready), 0);
        chk("R3 data", int'(mem_wdata), 0);
        chk("R3 imag addr", int'(mem_addr), exp_addr(region, k, 1));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        chk("R1 ready", int'(s_ready), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 we", int'(mem_we), 0);

        // Frame 1: table walk, region 21, idle gaps checked for R8.
        for (int k = 0; k < NPTS; k++) begin
            put(k, TBL[k].smp, 21, 1'b0);
            if (TBL[k].gap) begin
                @(negedge clk); #1;
                chk("R8 idle we", int'(mem_we), 0);
            end
        end
        @(negedge clk); #1;
        chk("R6 full", int'(full), 1);
        chk("R6 ready", int'(s_ready), 0);
        s_valid = 1; s_data = 16'hDEAD;
        for (int c = 0; c < 3; c++) begin
            #1; chk("R6 no write", int'(mem_we), 0);
            @(negedge clk);
        end
        chk("R6 still full", int'(full), 1);

        // Restart while a sample is offered.
        restart = 1; #1;
        chk("R7 quiet we", int'(mem_we), 0);
        chk("R7 quiet ready", int'(s_ready), 0);
        @(negedge clk); restart = 0; s_valid = 0; #1;
        chk("R7 full cleared", int'(full), 0);
        chk("R7 ready", int'(s_ready), 1);

        // Frame 2: back-to-back with valid held, region 3.
        put(0, 16'h0AAA, 3, 1'b1);
        put(1, 16'h0BBB, 3, 1'b1);
        put(2, 16'h0CCC, 3, 1'b0);
        chk("R9 back-to-back done", 1, 1);

        // Restart mid-pair: accept slot 3, restart during its imaginary cycle.
        @(negedge clk);
        s_valid = 1; s_data = 16'h1111; base_slot = 5'd7; #1;
        chk("R4 slot of k3", int'(mem_addr), exp_addr(7, 3, 0));
        @(negedge clk); s_valid = 0; restart = 1; #1;
        chk("R7 mid-pair no write", int'(mem_we), 0);
        @(negedge clk); restart = 0;
        put(0, 16'h2222, 7, 1'b0);
        chk("R7 restart to slot 0", 1, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule